// File: doc/BRIEF.md
# Per-Core Clock Divider with Staged Reload

This block derives a clock enable for each of up to four processor cores from one shared parent clock. Each core runs at one of three ratios to the parent: 1:1, 1:2 or 1:3. Software programs the ratios through a small register bus. The bus has a control word, a second control word and a divisor word with one 6-bit field per core.

A divisor written to the divisor word does not take effect at once. It is only staged. Software first marks the cores that should adopt new ratios by setting their reload bits in the control word. It then raises a trigger bit. On the rising edge of the trigger, each marked core records its clamped target. The core swaps to that target at the end of its current output period, so no period is cut short. Cores that are not marked keep running unchanged. A pending flag stays high until every marked core has made its switch.

The control word also carries a byte of per-domain reset outputs. The second control word carries a 6-bit fabric ratio, which is passed straight to an output.

Top module: `cdiv_top`

## Requirements
- R1: The control word is at byte offset 0x0, the second control word at 0x8 and the divisor word at 0xC. Core n's 6-bit divisor field sits at bits 8n+5..8n of the divisor word. Reads return the stored values; divisor-word bits outside the fields, and unmapped offsets, read as 0.
- R2: `core_clk_en[n]` is high for one cycle in every `r` cycles, where `r` is core n's active ratio, on the last cycle of each period. At ratio 1 it is high in every cycle.
- R3: Writing the divisor word alone never changes any active ratio.
- R4: The rising edge of control bit 24 stages a new target for every core n whose reload bit (control bit 20+n) is set. The target is the clamped value of that core's divisor field. The rising edge is seen one cycle after the write that sets the bit. Cores whose reload bit is clear are unaffected.
- R5: Clamping maps a field value of 0 to ratio 1 and any value above 3 to ratio 3. Values 1, 2 and 3 are used as written.
- R6: A staged target becomes active only on the last cycle of the core's current period. The next period then has the full new length.
- R7: `update_pending` goes high in the cycle after a trigger edge that selects at least one core. It goes low once every selected core has switched. A new edge while a switch is still outstanding replaces that core's target.
- R8: Clearing the reload bits or bit 24 changes no ratio. Holding bit 24 high causes no further reload.
- R9: `dom_rst` equals control bits 15:8. `fabric_ratio` equals bits 21:16 of the second control word.
- R10: After reset, every divisor field and every active ratio is 1, both control words are 0, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| core_clk_en | output | NCORE | Per-core divided clock enable |
| dom_rst | output | 8 | Per-domain reset outputs |
| fabric_ratio | output | 6 | Fabric clock ratio field |
| update_pending | output | 1 | A staged ratio switch is outstanding |

## Verification
The hardest case to reach is a trigger edge that lands near a ratio-3 core's period end. This includes an edge that arrives while that core still has a switch outstanding, and a switch and a new load in the same cycle. The stimulus reaches this case by setting cores to ratio 3 and then repeating the trigger sequence. Each repeat adds a further idle cycle of delay, so over the repeats the edge lands at every phase of the period. Clamp values 0 and above 3 are staged on cores that are not selected as well as on cores that are, to show that selection alone decides who switches.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int FIELD_W   = 6;
    localparam int LANE_W    = 8;
    localparam int RATIO_W   = 2;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CTRL2 = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_DIV   = 4'hC;
    localparam int TRIG_BIT  = 24;
    localparam int SEL_LSB   = 20;
    localparam int DRST_LSB  = 8;
    localparam int FAB_LSB   = 16;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic ratio_t clamp_ratio(input logic [FIELD_W-1:0] d);
        if (d == '0)
            return ratio_t'(1);
        else if (d > 6'd3)
            return ratio_t'(3);
        else
            return d[RATIO_W-1:0];
    endfunction
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
    import cdiv_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  bus_req_t                  req,
    output logic [DATA_W-1:0]         ctrl_q,
    output logic [DATA_W-1:0]         ctrl2_q,
    output logic [NCORE*FIELD_W-1:0]  fields,
    output logic [DATA_W-1:0]         rdata
);
    logic [DATA_W-1:0] div_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ctrl2_q <= '0;
        end else if (req.wr) begin
            if (req.addr == OFS_CTRL)  ctrl_q  <= req.wdata;
            if (req.addr == OFS_CTRL2) ctrl2_q <= req.wdata;
        end
    end

    for (genvar n = 0; n < NCORE; n++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)
                fields[n*FIELD_W +: FIELD_W] <= FIELD_W'(1);
            else if (req.wr && req.addr == OFS_DIV)
                fields[n*FIELD_W +: FIELD_W] <= req.wdata[n*LANE_W +: FIELD_W];
        end
    end

    always_comb begin
        div_word = '0;
        for (int n = 0; n < NCORE; n++)
            div_word[n*LANE_W +: FIELD_W] = fields[n*FIELD_W +: FIELD_W];
    end

    always_comb begin
        case (req.addr)
            OFS_CTRL:  rdata = ctrl_q;
            OFS_CTRL2: rdata = ctrl2_q;
            OFS_DIV:   rdata = div_word;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/cdiv_trig.sv
module cdiv_trig
    import cdiv_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      trig_bit,
    input  logic [NCORE-1:0]          sel,
    input  logic [NCORE*FIELD_W-1:0]  fields,
    output logic                      rise,
    output logic [NCORE-1:0]          load,
    output logic [NCORE*RATIO_W-1:0]  targets
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_bit;
    end

    assign rise = trig_bit & ~trig_q;
    assign load = {NCORE{rise}} & sel;

    for (genvar n = 0; n < NCORE; n++) begin : g_tgt
        assign targets[n*RATIO_W +: RATIO_W] = clamp_ratio(fields[n*FIELD_W +: FIELD_W]);
    end
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
    import cdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  ratio_t load_ratio,
    output logic   en,
    output ratio_t act,
    output logic   pend
);
    ratio_t cnt;
    ratio_t tgt;
    logic   at_end;

    assign at_end = (cnt == ratio_t'(act - ratio_t'(1)));
    assign en     = at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            act  <= ratio_t'(1);
            tgt  <= ratio_t'(1);
            pend <= 1'b0;
        end else begin
            if (at_end) begin
                cnt <= '0;
                if (pend) act <= tgt;
            end else begin
                cnt <= cnt + ratio_t'(1);
            end
            if (load) begin
                pend <= 1'b1;
                tgt  <= load_ratio;
            end else if (at_end) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
    import cdiv_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [3:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NCORE-1:0]     core_clk_en,
    output logic [7:0]           dom_rst,
    output logic [5:0]           fabric_ratio,
    output logic                 update_pending
);
    bus_req_t                   req;
    logic [DATA_W-1:0]          ctrl_q;
    logic [DATA_W-1:0]          ctrl2_q;
    logic [NCORE*FIELD_W-1:0]   fields;
    logic                       trig_rise;
    logic [NCORE-1:0]           reload_sel;
    logic [NCORE-1:0]           load_vec;
    logic [NCORE*RATIO_W-1:0]   tgt_flat;
    logic [NCORE*RATIO_W-1:0]   act_flat;
    logic [NCORE-1:0]           pend_vec;

    assign req = '{wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    cdiv_regs #(.NCORE(NCORE)) regs_i (
        .clk(clk), .rst(rst), .req(req),
        .ctrl_q(ctrl_q), .ctrl2_q(ctrl2_q), .fields(fields), .rdata(bus_rdata)
    );

    assign reload_sel = ctrl_q[SEL_LSB +: NCORE];

    cdiv_trig #(.NCORE(NCORE)) trig_i (
        .clk(clk), .rst(rst), .trig_bit(ctrl_q[TRIG_BIT]), .sel(reload_sel),
        .fields(fields), .rise(trig_rise), .load(load_vec), .targets(tgt_flat)
    );

    for (genvar n = 0; n < NCORE; n++) begin : g_core
        cdiv_core core_i (
            .clk(clk), .rst(rst),
            .load(load_vec[n]),
            .load_ratio(tgt_flat[n*RATIO_W +: RATIO_W]),
            .en(core_clk_en[n]),
            .act(act_flat[n*RATIO_W +: RATIO_W]),
            .pend(pend_vec[n])
        );
    end

    assign dom_rst        = ctrl_q[DRST_LSB +: 8];
    assign fabric_ratio   = ctrl2_q[FAB_LSB +: FIELD_W];
    assign update_pending = |pend_vec;
endmodule

// File: rtl/cdiv_chk.sv
module cdiv_chk #(
    parameter int NCORE = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NCORE-1:0]     en,
    input logic [NCORE-1:0]     pend,
    input logic [NCORE*2-1:0]   act,
    input logic                 rise,
    input logic [NCORE-1:0]     sel
);
    for (genvar n = 0; n < NCORE; n++) begin : g_chk
        AST_SWITCH_AT_END: assert property (@(posedge clk) disable iff (rst)
            !$stable(act[n*2 +: 2]) |-> $past(en[n] && pend[n])); // R6
        AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (pend[n] && en[n] && !(rise && sel[n])) |=> !pend[n]); // R7
        AST_LOAD_STAGES: assert property (@(posedge clk) disable iff (rst)
            (rise && sel[n]) |=> pend[n]); // R4
        AST_HALF_GAP: assert property (@(posedge clk) disable iff (rst)
            (en[n] && act[n*2 +: 2] == 2'd2 && !pend[n]) |=> !en[n]); // R2
    end
endmodule

bind cdiv_top cdiv_chk #(.NCORE(NCORE)) chk_i (
    .clk(clk), .rst(rst), .en(core_clk_en), .pend(pend_vec),
    .act(act_flat), .rise(trig_rise), .sel(reload_sel)
);

// File: tb/cdiv_top_tb_top.sv
module cdiv_top_tb_top;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] core_clk_en;
    logic [7:0]  dom_rst;
    logic [5:0]  fabric_ratio;
    logic        update_pending;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // behavioural reference state
    int          m_act[NC], m_cnt[NC], m_tgt[NC];
    bit          m_pend[NC];
    int          m_field[NC];
    logic [31:0] m_ctrl, m_ctrl2;
    bit          m_trigq;

    always #10 clk = ~clk;

    cdiv_top #(.NCORE(NC)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_clk_en(core_clk_en),
        .dom_rst(dom_rst), .fabric_ratio(fabric_ratio), .update_pending(update_pending)
    );

    function automatic int clampv(int d);
        if (d == 0) return 1;
        if (d > 3) return 3;
        return d;
    endfunction

    function automatic logic [31:0] m_read(logic [3:0] a);
        logic [31:0] w = '0;
        case (a)
            4'h0: w = m_ctrl;
            4'h8: w = m_ctrl2;
            4'hC: for (int n = 0; n < NC; n++) w[8*n +: 6] = 6'(m_field[n]);
            default: w = '0;
        endcase
        return w;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        bit rise;
        bit endp;
        cycles++;
        if (rst) begin
            for (int n = 0; n < NC; n++) begin
                m_act[n] = 1; m_cnt[n] = 0; m_tgt[n] = 1; m_pend[n] = 0; m_field[n] = 1;
            end
            m_ctrl = '0; m_ctrl2 = '0; m_trigq = 0;
        end else begin
            rise = m_ctrl[24] && !m_trigq;
            m_trigq = m_ctrl[24];
            for (int n = 0; n < NC; n++) begin
                endp = (m_cnt[n] == m_act[n] - 1);
                if (endp) begin
                    m_cnt[n] = 0;
                    if (m_pend[n]) begin m_act[n] = m_tgt[n]; m_pend[n] = 0; end
                end else m_cnt[n]++;
                if (rise && m_ctrl[20+n]) begin
                    m_pend[n] = 1; m_tgt[n] = clampv(m_field[n]);
                end
            end
            if (bus_wr) begin
                if (bus_addr == 4'h0) m_ctrl = bus_wdata;
                if (bus_addr == 4'h8) m_ctrl2 = bus_wdata;
                if (bus_addr == 4'hC)
                    for (int n = 0; n < NC; n++) m_field[n] = int'(bus_wdata[8*n +: 6]);
            end
        end
        #5;
        if (!rst) begin
            logic [NC-1:0] e_en;
            bit e_pend;
            e_pend = 0;
            for (int n = 0; n < NC; n++) begin
                e_en[n] = (m_cnt[n] == m_act[n] - 1);
                e_pend |= m_pend[n];
            end
            // R2 R3 R4 R5 R6 R8: enable pattern tracks the reference ratios
            check(core_clk_en == e_en, "R2/R6 core_clk_en", 32'(core_clk_en), 32'(e_en));
            check(update_pending == e_pend, "R7 update_pending", 32'(update_pending), 32'(e_pend));
            check(bus_rdata == m_read(bus_addr), "R1 bus_rdata", bus_rdata, m_read(bus_addr));
            check(dom_rst == m_ctrl[15:8], "R9 dom_rst", 32'(dom_rst), 32'(m_ctrl[15:8]));
            check(fabric_ratio == m_ctrl2[21:16], "R9 fabric_ratio", 32'(fabric_ratio), 32'(m_ctrl2[21:16]));
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            bus_addr = (i % 2 == 0) ? 4'hC : 4'h0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        bus_addr = 4'hC;
        @(posedge clk); #6;
        // R10 reset values
        check(bus_rdata == 32'h0101_0101, "R10 div word reset", bus_rdata, 32'h0101_0101);
        check(core_clk_en == '1, "R10 ratio 1 after reset", 32'(core_clk_en), 32'hF);
        check(update_pending == 1'b0, "R10 nothing pending", 32'(update_pending), 0);

        // R3: staging alone changes nothing
        wr(4'hC, 32'h0700_0302);
        idle(8);
        // R4: select cores 0 and 2, then trigger
        wr(4'h0, 32'h0050_0000);
        idle(3);
        wr(4'h0, 32'h0150_0000);
        idle(10);
        // R8: clear reload and trigger together
        wr(4'h0, 32'h0000_0000);
        idle(10);
        // R5: clamp on cores 1 and 3 (0 -> 1, 7 -> 3)
        wr(4'hC, 32'h0700_0003);
        wr(4'h0, 32'h00A0_0000);
        wr(4'h0, 32'h01A0_0000);
        idle(6);
        // R8: holding the trigger high does not reload
        wr(4'hC, 32'h0202_0202);
        idle(8);
        wr(4'h0, 32'h0000_0000);
        idle(4);
        // R7 R6: sweep trigger phase against ratio-3 cores, retrigger while pending
        for (int k = 0; k < 6; k++) begin
            wr(4'hC, (k % 2 == 0) ? 32'h0303_0303 : 32'h0102_3F00);
            wr(4'h0, 32'h00F0_0000);
            wr(4'h0, 32'h01F0_0000);
            idle(k);
            wr(4'h0, 32'h00F0_0000);
            wr(4'hC, 32'h0201_0302);
            wr(4'h0, 32'h01F0_0000);
            idle(k + 1);
            wr(4'h0, 32'h0000_0000);
        end
        idle(10);
        // R9: domain resets and fabric ratio
        wr(4'h0, 32'h0000_FF00);
        wr(4'h8, 32'h002A_0000);
        idle(2);
        wr(4'h4, 32'hFFFF_FFFF);
        bus_addr = 4'h4;
        idle(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule